// File: doc/BRIEF.md
# Floating-Point Register File with Bank Swap and Pair Moves

This block holds the floating-point register state of a scalar core. It has two physical banks of sixteen 32-bit words and a 32-bit transfer register that carries raw bit patterns to and from the integer side. At any moment one physical bank is the foreground view and the other is the background view. A mode bit supplied by the core's status register picks which bank plays which role, so flipping that bit swaps the two banks for every later access without moving any data.

The block decodes a 16-bit opcode on cycles when `op_valid` is high. It carries out register-to-register moves, the sign operations, the constant loads and the transfers to and from the transfer register. Two more opcodes toggle the pair-width and bank-swap mode bits. The new mode values appear combinationally on `mode_pair_nxt` and `mode_swap_nxt`, and the surrounding core feeds them back. When the pair-width bit is set, a move copies an aligned pair of words, and each side of the pair may come from either view.

Each opcode is sorted into an enumerated operation kind: NONE, MOV_S, MOV_P, ABS, NEG, LDS, STS, LDI0, LDI1, BANKSW and SZSW. There is no sequencing. Every operation completes at the clock edge that samples it. Reads of the register file are combinational.

Top module: `fprf_bank_unit`

## Requirements
- R1: After reset, every word of both physical banks and the transfer register read as zero.
- R2: With `mode_pair`=0, opcode 0xFnmC (low nibble 1100) copies foreground word m into foreground word n.
- R3: With `mode_pair`=1, opcode 0xFnmC copies a pair of words. The destination pair is opcode bits 11:9 and the source pair is bits 7:5. Bit 8 picks the destination view and bit 4 the source view (0 = foreground, 1 = background). Words 2p and 2p+1 are written from words 2q and 2q+1.
- R4: Opcode 0xFn5D clears bit 31 of foreground word n when `mode_dbl`=0. When `mode_dbl`=1 it clears bit 31 of word n with bit 0 forced to 0, and the odd word is left unchanged.
- R5: Opcode 0xFn4D inverts bit 31, using the same target-word rule as R4.
- R6: Opcode 0xFn1D copies foreground word n into the transfer register and changes no register word. Opcode 0xFn0D copies the transfer register into foreground word n. Both copy raw bits.
- R7: With `mode_dbl`=0, opcode 0xFn8D writes 0x00000000 and opcode 0xFn9D writes 0x3F800000 into foreground word n. With `mode_dbl`=1, both opcodes have no effect.
- R8: A valid 0xFBFD drives `mode_swap_nxt` to the inverse of `mode_swap`, and a valid 0xF3FD drives `mode_pair_nxt` to the inverse of `mode_pair`. In every other case both outputs equal their inputs.
- R9: When `mode_swap`=0 the foreground view is physical bank 0. When `mode_swap`=1 it is physical bank 1. The background view is always the other bank, and this mapping applies to reads, writes and pair moves alike.
- R10: When `op_valid` is low, or the opcode is not one listed here, no register word and no transfer-register bit changes, and the mode outputs mirror the mode inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 16 | Instruction word |
| mode_dbl | input | 1 | Double-precision mode bit |
| mode_pair | input | 1 | Pair-width move mode bit |
| mode_swap | input | 1 | Bank-swap mode bit |
| rd_view | input | 1 | Read view: 0 foreground, 1 background |
| rd_idx | input | 4 | Read word index |
| rd_data | output | 32 | Read data, combinational |
| xfer_q | output | 32 | Transfer register contents |
| mode_pair_nxt | output | 1 | Updated pair-width mode bit |
| mode_swap_nxt | output | 1 | Updated bank-swap mode bit |

## Verification
The bench covers all four bank combinations of the pair move. A design that confused the destination-bank bit (8) with the source-bank bit (4) would place data in the wrong bank. Sign operations with `mode_dbl`=1 are aimed at odd word numbers, where a design that ignored the even-word rule would alter the odd word instead. Constant loads are issued in double mode, where a faulty design would overwrite a register. Data written before a bank swap is read back through the opposite view afterwards, and a swap applied to reads but not to writes shows up as stale words.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

    localparam int OPW = 16;
    localparam logic [31:0] UNIT_ONE = 32'h3F80_0000;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_MOV_S,
        OP_MOV_P,
        OP_ABS,
        OP_NEG,
        OP_LDS,
        OP_STS,
        OP_LDI0,
        OP_LDI1,
        OP_BANKSW,
        OP_SZSW
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [3:0] n;
        logic [3:0] m;
    } op_dec_t;

endpackage

// File: rtl/fprf_decode.sv
module fprf_decode
    import fprf_pkg::*;
(
    input  logic [OPW-1:0] op_code,
    input  logic           mode_pair,
    output op_dec_t        dec
);
    always_comb begin
        dec.n    = op_code[11:8];
        dec.m    = op_code[7:4];
        dec.kind = OP_NONE;
        if (op_code[15:12] == 4'hF) begin
            unique case (op_code[3:0])
                4'hC: dec.kind = mode_pair ? OP_MOV_P : OP_MOV_S;
                4'hD: begin
                    unique case (op_code[7:4])
                        4'h0: dec.kind = OP_STS;
                        4'h1: dec.kind = OP_LDS;
                        4'h4: dec.kind = OP_NEG;
                        4'h5: dec.kind = OP_ABS;
                        4'h8: dec.kind = OP_LDI0;
                        4'h9: dec.kind = OP_LDI1;
                        4'hF: begin
                            if (op_code[11:8] == 4'hB)
                                dec.kind = OP_BANKSW;
                            else if (op_code[11:8] == 4'h3)
                                dec.kind = OP_SZSW;
                        end
                        default: dec.kind = OP_NONE;
                    endcase
                end
                default: dec.kind = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/fprf_store.sv
module fprf_store #(
    parameter int DW    = 32,
    parameter int WORDS = 16,
    parameter int NRD   = 3,
    parameter int NWR   = 2,
    localparam int IDXW = $clog2(WORDS),
    localparam int AW   = IDXW + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NWR-1:0]           we,
    input  logic [NWR-1:0][AW-1:0]   wa,
    input  logic [NWR-1:0][DW-1:0]   wd,
    input  logic [NRD-1:0][AW-1:0]   ra,
    output logic [NRD-1:0][DW-1:0]   rdata
);
    logic [DW-1:0] bank_q [2][WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int w = 0; w < WORDS; w++)
                    bank_q[b][w] <= '0;
        end else begin
            for (int l = 0; l < NWR; l++)
                if (we[l])
                    bank_q[wa[l][AW-1]][wa[l][IDXW-1:0]] <= wd[l];
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = bank_q[ra[p][AW-1]][ra[p][IDXW-1:0]];
    end
endmodule

// File: rtl/fprf_write_ctl.sv
module fprf_write_ctl
    import fprf_pkg::*;
#(
    parameter int DW   = 32,
    parameter int IDXW = 4,
    localparam int AW  = IDXW + 1
) (
    input  logic                 op_valid,
    input  op_dec_t              dec,
    input  logic                 mode_dbl,
    input  logic                 mode_pair,
    input  logic                 mode_swap,
    input  logic [DW-1:0]        src_a,
    input  logic [DW-1:0]        src_b,
    input  logic [DW-1:0]        xfer_q,
    output logic [AW-1:0]        ra_a,
    output logic [AW-1:0]        ra_b,
    output logic [1:0]           we,
    output logic [1:0][AW-1:0]   wa,
    output logic [1:0][DW-1:0]   wd,
    output logic                 xfer_we,
    output logic [DW-1:0]        xfer_d,
    output logic                 mode_pair_nxt,
    output logic                 mode_swap_nxt
);
    logic            fg_bank;
    logic [IDXW-1:0] sign_tgt;
    logic            src_bank, dst_bank;

    assign fg_bank  = mode_swap;
    assign sign_tgt = mode_dbl ? {dec.n[IDXW-1:1], 1'b0} : dec.n;
    assign src_bank = dec.m[0] ^ mode_swap;
    assign dst_bank = dec.n[0] ^ mode_swap;

    always_comb begin
        ra_a          = {fg_bank, dec.n};
        ra_b          = {src_bank, dec.m[IDXW-1:1], 1'b1};
        we            = '0;
        wa            = '0;
        wd            = '0;
        xfer_we       = 1'b0;
        xfer_d        = src_a;
        mode_pair_nxt = mode_pair;
        mode_swap_nxt = mode_swap;
        unique case (dec.kind)
            OP_MOV_S: begin
                ra_a  = {fg_bank, dec.m};
                we[0] = op_valid;
                wa[0] = {fg_bank, dec.n};
                wd[0] = src_a;
            end
            OP_MOV_P: begin
                ra_a  = {src_bank, dec.m[IDXW-1:1], 1'b0};
                we    = {op_valid, op_valid};
                wa[0] = {dst_bank, dec.n[IDXW-1:1], 1'b0};
                wa[1] = {dst_bank, dec.n[IDXW-1:1], 1'b1};
                wd[0] = src_a;
                wd[1] = src_b;
            end
            OP_ABS: begin
                ra_a  = {fg_bank, sign_tgt};
                we[0] = op_valid;
                wa[0] = {fg_bank, sign_tgt};
                wd[0] = {1'b0, src_a[DW-2:0]};
            end
            OP_NEG: begin
                ra_a  = {fg_bank, sign_tgt};
                we[0] = op_valid;
                wa[0] = {fg_bank, sign_tgt};
                wd[0] = {~src_a[DW-1], src_a[DW-2:0]};
            end
            OP_LDS: xfer_we = op_valid;
            OP_STS: begin
                we[0] = op_valid;
                wa[0] = {fg_bank, dec.n};
                wd[0] = xfer_q;
            end
            OP_LDI0: begin
                we[0] = op_valid && !mode_dbl;
                wa[0] = {fg_bank, dec.n};
                wd[0] = '0;
            end
            OP_LDI1: begin
                we[0] = op_valid && !mode_dbl;
                wa[0] = {fg_bank, dec.n};
                wd[0] = DW'(UNIT_ONE);
            end
            OP_BANKSW: mode_swap_nxt = mode_swap ^ op_valid;
            OP_SZSW:   mode_pair_nxt = mode_pair ^ op_valid;
            OP_NONE:   ;
            default:   ;
        endcase
    end
endmodule

// File: rtl/fprf_bank_unit.sv
module fprf_bank_unit
    import fprf_pkg::*;
#(
    parameter int DW    = 32,
    localparam int IDXW = 4,
    localparam int WORDS = 1 << IDXW,
    localparam int AW   = IDXW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [15:0]     op_code,
    input  logic            mode_dbl,
    input  logic            mode_pair,
    input  logic            mode_swap,
    input  logic            rd_view,
    input  logic [3:0]      rd_idx,
    output logic [DW-1:0]   rd_data,
    output logic [DW-1:0]   xfer_q,
    output logic            mode_pair_nxt,
    output logic            mode_swap_nxt
);
    op_dec_t               dec;
    logic [2:0][AW-1:0]    ra;
    logic [2:0][DW-1:0]    rdata;
    logic [1:0]            we;
    logic [1:0][AW-1:0]    wa;
    logic [1:0][DW-1:0]    wd;
    logic                  xfer_we;
    logic [DW-1:0]         xfer_d;

    fprf_decode u_dec (
        .op_code   (op_code),
        .mode_pair (mode_pair),
        .dec       (dec)
    );

    fprf_write_ctl #(.DW(DW), .IDXW(IDXW)) u_ctl (
        .op_valid      (op_valid),
        .dec           (dec),
        .mode_dbl      (mode_dbl),
        .mode_pair     (mode_pair),
        .mode_swap     (mode_swap),
        .src_a         (rdata[0]),
        .src_b         (rdata[1]),
        .xfer_q        (xfer_q),
        .ra_a          (ra[0]),
        .ra_b          (ra[1]),
        .we            (we),
        .wa            (wa),
        .wd            (wd),
        .xfer_we       (xfer_we),
        .xfer_d        (xfer_d),
        .mode_pair_nxt (mode_pair_nxt),
        .mode_swap_nxt (mode_swap_nxt)
    );

    assign ra[2]   = {rd_view ^ mode_swap, rd_idx};
    assign rd_data = rdata[2];

    fprf_store #(.DW(DW), .WORDS(WORDS), .NRD(3), .NWR(2)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .wa    (wa),
        .wd    (wd),
        .ra    (ra),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            xfer_q <= '0;
        else if (xfer_we)
            xfer_q <= xfer_d;
    end
endmodule

// File: rtl/fprf_checker.sv
module fprf_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [15:0]   op_code,
    input logic          mode_dbl,
    input logic          mode_pair,
    input logic          mode_swap,
    input logic          rd_view,
    input logic [3:0]    rd_idx,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] xfer_q,
    input logic          mode_pair_nxt,
    input logic          mode_swap_nxt
);
    logic is_lds, is_ldi;
    assign is_lds = op_valid && op_code[15:12] == 4'hF && op_code[7:0] == 8'h1D;
    assign is_ldi = op_valid && op_code[15:12] == 4'hF && op_code[7:5] == 3'b100
                    && op_code[3:0] == 4'hD;

    AST_IDLE_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (mode_pair_nxt == mode_pair && mode_swap_nxt == mode_swap)); // R10
    AST_SWAP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 16'hFBFD) |-> mode_swap_nxt != mode_swap); // R8
    AST_PAIR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 16'hF3FD) |-> mode_pair_nxt != mode_pair); // R8
    AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_lds |=> $stable(xfer_q)); // R6
    AST_LDS_NO_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        is_lds ##1 ($stable(rd_view) && $stable(rd_idx) && $stable(mode_swap))
        |-> $stable(rd_data)); // R6
    AST_LDI_DBL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ldi && mode_dbl) ##1 ($stable(rd_view) && $stable(rd_idx) && $stable(mode_swap))
        |-> $stable(rd_data)); // R7
endmodule

bind fprf_bank_unit fprf_checker #(.DW(DW)) u_fprf_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_code       (op_code),
    .mode_dbl      (mode_dbl),
    .mode_pair     (mode_pair),
    .mode_swap     (mode_swap),
    .rd_view       (rd_view),
    .rd_idx        (rd_idx),
    .rd_data       (rd_data),
    .xfer_q        (xfer_q),
    .mode_pair_nxt (mode_pair_nxt),
    .mode_swap_nxt (mode_swap_nxt)
);

// File: tb/test_fprf_bank_unit.sv
module test_fprf_bank_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] op_code = 16'h0000;
    logic        mode_dbl = 1'b0, mode_pair = 1'b0, mode_swap = 1'b0;
    logic        rd_view = 1'b0;
    logic [3:0]  rd_idx = 4'h0;
    logic [31:0] rd_data, xfer_q;
    logic        mode_pair_nxt, mode_swap_nxt;
    logic        seen_pair_nxt, seen_swap_nxt;
    int          n_tests = 0, n_fail = 0;

    localparam logic [31:0] ONE = 32'h3F80_0000;
    localparam logic [31:0] NEG0 = 32'h8000_0000;

    fprf_bank_unit i_fprf_bank_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .mode_dbl(mode_dbl), .mode_pair(mode_pair), .mode_swap(mode_swap),
        .rd_view(rd_view), .rd_idx(rd_idx), .rd_data(rd_data), .xfer_q(xfer_q),
        .mode_pair_nxt(mode_pair_nxt), .mode_swap_nxt(mode_swap_nxt)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] op, input logic vld);
        @(negedge clk);
        op_valid = vld;
        op_code  = op;
        #5;
        seen_pair_nxt = mode_pair_nxt;
        seen_swap_nxt = mode_swap_nxt;
        @(negedge clk);
        op_valid = 1'b0;
        op_code  = 16'h0000;
    endtask

    task automatic chk_reg(input string tag, input logic v, input logic [3:0] i,
                           input logic [31:0] exp);
        rd_view = v;
        rd_idx  = i;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic t_reset;
        int bad = 0;
        for (int v = 0; v < 2; v++)
            for (int i = 0; i < 16; i++) begin
                rd_view = v[0];
                rd_idx  = i[3:0];
                #1;
                if (rd_data !== 32'h0) bad++;
            end
        check("R1 all words zero (mismatch count)", bad, 0);
        check("R1 transfer register zero", xfer_q, 32'h0);
    endtask

    task automatic t_const;
        mode_dbl = 1'b0;
        run_op(16'hF39D, 1'b1);
        chk_reg("R7 load one FR3", 1'b0, 4'd3, ONE);
        run_op(16'hF38D, 1'b1);
        chk_reg("R7 load zero FR3", 1'b0, 4'd3, 32'h0);
        run_op(16'hF59D, 1'b1);
        chk_reg("R7 load one FR5", 1'b0, 4'd5, ONE);
        mode_dbl = 1'b1;
        run_op(16'hF58D, 1'b1);
        chk_reg("R7 dbl mode zero load ignored", 1'b0, 4'd5, ONE);
        run_op(16'hF69D, 1'b1);
        chk_reg("R7 dbl mode one load ignored", 1'b0, 4'd6, 32'h0);
        mode_dbl = 1'b0;
    endtask

    task automatic t_sign;
        mode_dbl = 1'b0;
        run_op(16'hF54D, 1'b1);
        chk_reg("R5 negate FR5", 1'b0, 4'd5, 32'hBF80_0000);
        run_op(16'hF55D, 1'b1);
        chk_reg("R4 abs FR5", 1'b0, 4'd5, ONE);
        run_op(16'hF04D, 1'b1);
        chk_reg("R5 negate zero FR0", 1'b0, 4'd0, NEG0);
        mode_dbl = 1'b1;
        run_op(16'hF54D, 1'b1);
        chk_reg("R5 dbl negate hits even FR4", 1'b0, 4'd4, NEG0);
        chk_reg("R5 dbl negate leaves odd FR5", 1'b0, 4'd5, ONE);
        run_op(16'hF15D, 1'b1);
        chk_reg("R4 dbl abs hits even FR0", 1'b0, 4'd0, 32'h0);
        mode_dbl = 1'b0;
    endtask

    task automatic t_single_move;
        mode_pair = 1'b0;
        run_op(16'hF95C, 1'b1);
        chk_reg("R2 move FR5 to FR9", 1'b0, 4'd9, ONE);
        run_op(16'hF24C, 1'b1);
        chk_reg("R2 move FR4 to FR2", 1'b0, 4'd2, NEG0);
    endtask

    task automatic t_xfer;
        run_op(16'hF41D, 1'b1);
        check("R6 FR4 to transfer", xfer_q, NEG0);
        chk_reg("R6 source FR4 unchanged", 1'b0, 4'd4, NEG0);
        run_op(16'hFB0D, 1'b1);
        chk_reg("R6 transfer to FR11", 1'b0, 4'd11, NEG0);
        run_op(16'hF91D, 1'b1);
        check("R6 FR9 to transfer", xfer_q, ONE);
    endtask

    task automatic t_pair;
        mode_pair = 1'b1;
        run_op(16'hF74C, 1'b1);
        chk_reg("R3 fg pair2 to bg pair3 low", 1'b1, 4'd6, NEG0);
        chk_reg("R3 fg pair2 to bg pair3 high", 1'b1, 4'd7, ONE);
        chk_reg("R3 fg word6 not written", 1'b0, 4'd6, 32'h0);
        run_op(16'hFB7C, 1'b1);
        chk_reg("R3 bg to bg low", 1'b1, 4'd10, NEG0);
        chk_reg("R3 bg to bg high", 1'b1, 4'd11, ONE);
        run_op(16'hFEBC, 1'b1);
        chk_reg("R3 bg to fg low", 1'b0, 4'd14, NEG0);
        chk_reg("R3 bg to fg high", 1'b0, 4'd15, ONE);
        run_op(16'hF08C, 1'b1);
        chk_reg("R3 fg to fg low", 1'b0, 4'd0, 32'h0);
        chk_reg("R3 fg to fg high", 1'b0, 4'd1, ONE);
    endtask

    task automatic t_swap;
        run_op(16'hFBFD, 1'b1);
        check("R8 bank swap toggles", {31'd0, seen_swap_nxt}, 32'd1);
        check("R8 pair bit unchanged on swap", {31'd0, seen_pair_nxt}, 32'd1);
        mode_swap = 1'b1;
        chk_reg("R9 swapped fg reads old bg word6", 1'b0, 4'd6, NEG0);
        chk_reg("R9 swapped bg reads old fg word5", 1'b1, 4'd5, ONE);
        run_op(16'hF64D, 1'b1);
        run_op(16'hFBFD, 1'b1);
        check("R8 bank swap toggles back", {31'd0, seen_swap_nxt}, 32'd0);
        mode_swap = 1'b0;
        chk_reg("R9 write under swap landed in bank1", 1'b1, 4'd6, 32'h0);
        chk_reg("R9 bank0 word4 intact", 1'b0, 4'd4, NEG0);
        run_op(16'hF3FD, 1'b1);
        check("R8 pair mode toggles", {31'd0, seen_pair_nxt}, 32'd0);
        mode_pair = 1'b0;
    endtask

    task automatic t_idle;
        run_op(16'hF39D, 1'b0);
        chk_reg("R10 invalid strobe no write", 1'b0, 4'd3, 32'h0);
        run_op(16'hFBFD, 1'b0);
        check("R10 mode mirror when idle", {31'd0, seen_swap_nxt}, 32'd0);
        run_op(16'h0123, 1'b1);
        chk_reg("R10 unknown opcode FR5 intact", 1'b0, 4'd5, ONE);
        check("R10 unknown opcode transfer intact", xfer_q, ONE);
        run_op(16'hF41D, 1'b0);
        check("R10 idle transfer load ignored", xfer_q, ONE);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_const();
        t_sign();
        t_single_move();
        t_xfer();
        t_pair();
        t_swap();
        t_idle();
        finish_run();
    end
endmodule